// File: doc/BRIEF.md
# Register-Mapped I2C Host Command Controller

This block sits between a byte-wide register port and a separate bit-level I2C bus engine. Software programs five registers: own address, clock divider, control, status and data. The block turns those accesses into byte-level bus commands: start-with-address, send byte, receive byte and stop. It passes each command to the engine over a valid/ready handshake. It then waits for a one-cycle response that carries the acknowledge result, an arbitration-lost indication and any received byte.

The block tracks whether a target address is held, and it keeps the bus-busy, received-NACK, arbitration-lost and interrupt flags. When a register access needs the bus engine, `regReady` stays low until the engine has answered. The host holds its request and write data until it sees `regReady` high at a rising clock edge. The divider and own-address values are only stored. Clock generation and slave operation belong elsewhere.

Register select codes: 0 own address, 1 divider, 2 control, 3 status, 4 data; 5 to 7 are unmapped.
Control bits: 7 enable, 6 interrupt enable, 5 master, 4 transmit direction, 3 spare (stored only), 2 repeated start. Status bits: 5 busy, 4 arbitration lost, 1 interrupt flag, 0 received NACK.
Bus opcodes on `cmdOp`: 0 start-with-address, 1 send, 2 receive, 3 stop.

Top module: `i2c_host_regs`

## Requirements
- R1: Each register stores its write masked: own address with 0xFE, divider with 0x3F, control with 0xFC. Reads of select codes 5 to 7 return 0, and writes to them change nothing.
- R2: A control write that clears bit 7 while the module is enabled is a soft reset. Divider, control, status, data latch and held address return to 0, and the own-address register keeps its value. If an address was held, a stop command (opcode 3) is issued first.
- R3: A normal control write copies bit 5 into the busy status bit. When bit 5 is written as 0 while an address is held, a stop command is issued and the address is dropped.
- R4: A control write with bit 2 set while an address is held issues a stop, drops the address and leaves bit 2 reading back as 0.
- R5: Status bits 1 and 4 clear only when they are set and written with 0. Writes can set no status bit. The `irq` output equals status bit 1.
- R6: A successful bus step sets the interrupt flag only when control bits 7 and 6 are both 1.
- R7: Data writes while control bit 7 is 0 issue no command.
- R8: In master mode with no address held, a data write issues opcode 0 with that byte. NACK sets status bit 0. ACK stores the address, clears bit 0 and raises the interrupt.
- R9: With an address held, a data write issues opcode 1. ACK clears status bit 0 and raises the interrupt. NACK sets bit 0, drops the address and is followed by a stop.
- R10: A data read returns the byte latched before the read. In master mode with an address held and bit 4 clear, it then receives a new byte (opcode 2) into the latch and raises the interrupt. In master mode otherwise, the latch becomes 0xFF and no command is issued.
- R11: A command is held stable until accepted. A register access that needs the engine completes only after the response arrives, while other accesses complete in the cycle they are presented. A response with `respLost` set sets status bit 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| regSel | input | 3 | Register select code |
| regWrEn | input | 1 | Write request (wins over read) |
| regRdEn | input | 1 | Read request |
| regWdata | input | 8 | Write data |
| regRdata | output | 8 | Read data, valid when regReady is high |
| regReady | output | 1 | Access completes at this edge |
| cmdValid | output | 1 | Bus command present |
| cmdReady | input | 1 | Engine accepts the command |
| cmdOp | output | 2 | Bus opcode |
| cmdByte | output | 8 | Address or data byte of the command |
| respValid | input | 1 | One-cycle engine response |
| respNack | input | 1 | Target did not acknowledge |
| respLost | input | 1 | Arbitration lost during the step |
| respByte | input | 8 | Received byte for a receive step |
| irq | output | 1 | Interrupt line |

## Verification
The bench checks that a send refused with NACK is followed by a stop and that the next data write is treated as an address again. A design that kept the address would send it as data to the wrong target. The pipelined read is checked across three reads. A design that returned the fresh byte would be one read early, and one that skipped the 0xFF substitution would return stale data. Soft reset is tested with a transfer active: losing the own address or skipping the stop would leave the bus held. The bench also tests that writing 1s to status sets no flag and that the interrupt stays low with interrupt enable off.

// File: rtl/i2c_host_pkg.sv
package i2c_host_pkg;
  localparam int DW   = 8;
  localparam int SELW = 3;

  typedef enum logic [1:0] {
    OP_START = 2'd0,
    OP_SEND  = 2'd1,
    OP_RECV  = 2'd2,
    OP_STOP  = 2'd3
  } busOp_e;

  typedef enum logic [1:0] {
    ST_IDLE, ST_ISSUE, ST_WAIT, ST_DONE
  } seqState_e;

  localparam logic [SELW-1:0] SEL_OWN  = 3'd0;
  localparam logic [SELW-1:0] SEL_DIV  = 3'd1;
  localparam logic [SELW-1:0] SEL_CTL  = 3'd2;
  localparam logic [SELW-1:0] SEL_STAT = 3'd3;
  localparam logic [SELW-1:0] SEL_DAT  = 3'd4;

  localparam int CB_EN   = 7;
  localparam int CB_IEN  = 6;
  localparam int CB_MST  = 5;
  localparam int CB_TX   = 4;
  localparam int CB_RSTA = 2;

  localparam int SB_BUSY = 5;
  localparam int SB_ARB  = 4;
  localparam int SB_IRQ  = 1;
  localparam int SB_NACK = 0;

  typedef struct packed {
    logic wrOwn;
    logic wrDiv;
    logic wrCtl;
    logic softRst;
    logic wrStat;
    logic holdRd;
    logic rdDummy;
    logic rspAddr;
    logic rspSend;
    logic rspRecv;
    logic showHold;
  } strobe_t;
endpackage

// File: rtl/i2c_host_ctrl.sv
module i2c_host_ctrl
  import i2c_host_pkg::*;
(
  input  logic            clk,
  input  logic            rstN,
  input  logic [SELW-1:0] regSel,
  input  logic            regWrEn,
  input  logic            regRdEn,
  input  logic [DW-1:0]   regWdata,
  input  logic            ctlEn,
  input  logic            ctlMaster,
  input  logic            ctlTx,
  input  logic            addrValid,
  input  logic            cmdReady,
  input  logic            respValid,
  input  logic            respNack,
  output strobe_t         strb,
  output logic            regReady,
  output logic            cmdValid,
  output logic [1:0]      cmdOp,
  output logic [DW-1:0]   cmdByte
);
  seqState_e state;
  busOp_e    opReg;
  logic [DW-1:0] byteReg;

  logic acc, isWr, wrCtl, softRst, ctlStop, busWr, rdDat, rdFetch, needBus;
  logic rspHit;

  always_comb begin
    acc     = (state == ST_IDLE) && (regWrEn || regRdEn);
    isWr    = regWrEn;
    wrCtl   = acc && isWr && (regSel == SEL_CTL);
    softRst = wrCtl && ctlEn && !regWdata[CB_EN];
    ctlStop = wrCtl && addrValid &&
              (softRst || !regWdata[CB_MST] || regWdata[CB_RSTA]);
    busWr   = acc && isWr && (regSel == SEL_DAT) && ctlEn && ctlMaster;
    rdDat   = acc && !isWr && (regSel == SEL_DAT);
    rdFetch = rdDat && ctlMaster && addrValid && !ctlTx;
    needBus = ctlStop || busWr || rdFetch;
    rspHit  = (state == ST_WAIT) && respValid;

    strb          = '0;
    strb.wrOwn    = acc && isWr && (regSel == SEL_OWN);
    strb.wrDiv    = acc && isWr && (regSel == SEL_DIV);
    strb.wrCtl    = wrCtl && !softRst;
    strb.softRst  = softRst;
    strb.wrStat   = acc && isWr && (regSel == SEL_STAT);
    strb.holdRd   = rdDat;
    strb.rdDummy  = rdDat && ctlMaster && !rdFetch;
    strb.rspAddr  = rspHit && (opReg == OP_START);
    strb.rspSend  = rspHit && (opReg == OP_SEND);
    strb.rspRecv  = rspHit && (opReg == OP_RECV);
    strb.showHold = (state == ST_DONE);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      opReg   <= OP_STOP;
      byteReg <= '0;
    end else begin
      unique case (state)
        ST_IDLE: if (needBus) begin
          state   <= ST_ISSUE;
          byteReg <= regWdata;
          if (ctlStop)      opReg <= OP_STOP;
          else if (busWr)   opReg <= addrValid ? OP_SEND : OP_START;
          else              opReg <= OP_RECV;
        end
        ST_ISSUE: if (cmdReady) state <= ST_WAIT;
        ST_WAIT: if (respValid) begin
          if (opReg == OP_SEND && respNack) begin
            opReg <= OP_STOP;
            state <= ST_ISSUE;
          end else begin
            state <= ST_DONE;
          end
        end
        ST_DONE: state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign regReady = ((state == ST_IDLE) && !needBus) || (state == ST_DONE);
  assign cmdValid = (state == ST_ISSUE);
  assign cmdOp    = opReg;
  assign cmdByte  = byteReg;

  // R11
  cmd_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid && !cmdReady |=> cmdValid && $stable(cmdOp) && $stable(cmdByte));

  // R11
  cmd_stall_chk: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid |-> !regReady);

  // R9
  nack_stop_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.rspSend && respNack |=> cmdValid && cmdOp == OP_STOP);
endmodule

// File: rtl/i2c_host_dpath.sv
module i2c_host_dpath
  import i2c_host_pkg::*;
#(
  parameter logic [DW-1:0] OWN_MASK = 8'hFE,
  parameter logic [DW-1:0] DIV_MASK = 8'h3F,
  parameter logic [DW-1:0] CTL_MASK = 8'hFC
)(
  input  logic            clk,
  input  logic            rstN,
  input  strobe_t         strb,
  input  logic [SELW-1:0] regSel,
  input  logic [DW-1:0]   regWdata,
  input  logic            respNack,
  input  logic            respLost,
  input  logic [DW-1:0]   respByte,
  output logic [DW-1:0]   regRdata,
  output logic            ctlEn,
  output logic            ctlMaster,
  output logic            ctlTx,
  output logic            addrValid,
  output logic            irq
);
  localparam logic [DW-1:0] RSTA_BIT = DW'(1) << CB_RSTA;
  localparam logic [DW-1:0] ALL_ONES = '1;

  logic [DW-1:0] ownAddr, divReg, ctlReg, rdLatch, rdHold;
  logic busy, arbLost, irqFlag, rxNack, raiseOk;
  logic [DW-1:0] statusWord;

  assign raiseOk = ctlReg[CB_EN] && ctlReg[CB_IEN];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ownAddr <= '0; divReg <= '0; ctlReg <= '0;
      rdLatch <= '0; rdHold <= '0;
      busy <= 1'b0; arbLost <= 1'b0; irqFlag <= 1'b0; rxNack <= 1'b0;
      addrValid <= 1'b0;
    end else if (strb.softRst) begin
      divReg <= '0; ctlReg <= '0; rdLatch <= '0;
      busy <= 1'b0; arbLost <= 1'b0; irqFlag <= 1'b0; rxNack <= 1'b0;
      addrValid <= 1'b0;
    end else begin
      if (strb.wrOwn) ownAddr <= regWdata & OWN_MASK;
      if (strb.wrDiv) divReg  <= regWdata & DIV_MASK;
      if (strb.wrCtl) begin
        ctlReg <= regWdata & CTL_MASK & ~((addrValid && regWdata[CB_RSTA]) ? RSTA_BIT : '0);
        busy   <= regWdata[CB_MST];
        if (!regWdata[CB_MST] || regWdata[CB_RSTA]) addrValid <= 1'b0;
      end
      if (strb.wrStat) begin
        irqFlag <= irqFlag & regWdata[SB_IRQ];
        arbLost <= arbLost & regWdata[SB_ARB];
      end
      if (strb.holdRd)  rdHold  <= rdLatch;
      if (strb.rdDummy) rdLatch <= ALL_ONES;
      if (strb.rspAddr) begin
        if (respNack) rxNack <= 1'b1;
        else begin
          addrValid <= 1'b1;
          rxNack    <= 1'b0;
          if (raiseOk) irqFlag <= 1'b1;
        end
      end
      if (strb.rspSend) begin
        if (respNack) begin
          rxNack    <= 1'b1;
          addrValid <= 1'b0;
        end else begin
          rxNack <= 1'b0;
          if (raiseOk) irqFlag <= 1'b1;
        end
      end
      if (strb.rspRecv) begin
        rdLatch <= respByte;
        if (raiseOk) irqFlag <= 1'b1;
      end
      if ((strb.rspAddr || strb.rspSend || strb.rspRecv) && respLost) arbLost <= 1'b1;
    end
  end

  always_comb begin
    statusWord          = '0;
    statusWord[SB_BUSY] = busy;
    statusWord[SB_ARB]  = arbLost;
    statusWord[SB_IRQ]  = irqFlag;
    statusWord[SB_NACK] = rxNack;
    unique case (regSel)
      SEL_OWN:  regRdata = ownAddr;
      SEL_DIV:  regRdata = divReg;
      SEL_CTL:  regRdata = ctlReg;
      SEL_STAT: regRdata = statusWord;
      SEL_DAT:  regRdata = strb.showHold ? rdHold : rdLatch;
      default:  regRdata = '0;
    endcase
  end

  assign ctlEn     = ctlReg[CB_EN];
  assign ctlMaster = ctlReg[CB_MST];
  assign ctlTx     = ctlReg[CB_TX];
  assign irq       = irqFlag;

  // R6
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irqFlag) |-> ctlReg[CB_EN] && ctlReg[CB_IEN]);

  // R5
  irq_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(irqFlag) |-> $past(strb.wrStat || strb.softRst));

  // R2
  own_keep_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(strb.softRst) |-> ownAddr == $past(ownAddr));
endmodule

// File: rtl/i2c_host_regs.sv
module i2c_host_regs
  import i2c_host_pkg::*;
#(
  parameter logic [7:0] OWN_MASK = 8'hFE,
  parameter logic [7:0] DIV_MASK = 8'h3F,
  parameter logic [7:0] CTL_MASK = 8'hFC
)(
  input  logic       clk,
  input  logic       rstN,
  input  logic [2:0] regSel,
  input  logic       regWrEn,
  input  logic       regRdEn,
  input  logic [7:0] regWdata,
  output logic [7:0] regRdata,
  output logic       regReady,
  output logic       cmdValid,
  input  logic       cmdReady,
  output logic [1:0] cmdOp,
  output logic [7:0] cmdByte,
  input  logic       respValid,
  input  logic       respNack,
  input  logic       respLost,
  input  logic [7:0] respByte,
  output logic       irq
);
  strobe_t strb;
  logic ctlEn, ctlMaster, ctlTx, addrValid;

  i2c_host_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .regSel(regSel), .regWrEn(regWrEn),
    .regRdEn(regRdEn), .regWdata(regWdata), .ctlEn(ctlEn),
    .ctlMaster(ctlMaster), .ctlTx(ctlTx), .addrValid(addrValid),
    .cmdReady(cmdReady), .respValid(respValid), .respNack(respNack),
    .strb(strb), .regReady(regReady), .cmdValid(cmdValid),
    .cmdOp(cmdOp), .cmdByte(cmdByte)
  );

  i2c_host_dpath #(
    .OWN_MASK(OWN_MASK), .DIV_MASK(DIV_MASK), .CTL_MASK(CTL_MASK)
  ) uDpath (
    .clk(clk), .rstN(rstN), .strb(strb), .regSel(regSel),
    .regWdata(regWdata), .respNack(respNack), .respLost(respLost),
    .respByte(respByte), .regRdata(regRdata), .ctlEn(ctlEn),
    .ctlMaster(ctlMaster), .ctlTx(ctlTx), .addrValid(addrValid), .irq(irq)
  );
endmodule

// File: tb/tb_i2c_host_regs.sv
`timescale 1ns/1ps
module tb_i2c_host_regs;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [2:0] regSel = '0;
  logic regWrEn = 1'b0, regRdEn = 1'b0;
  logic [7:0] regWdata = '0;
  logic [7:0] regRdata;
  logic regReady, cmdValid, irq;
  logic cmdReady = 1'b0;
  logic [1:0] cmdOp;
  logic [7:0] cmdByte;
  logic respValid = 1'b0, respNack = 1'b0, respLost = 1'b0;
  logic [7:0] respByte = '0;

  int checks = 0, fails = 0;
  int cmdCount = 0, stallCnt = 0;
  logic [1:0] lastOp = '0, prevOp = '0;
  logic [7:0] lastByte = '0, rd;
  logic nackNext = 1'b0, lostNext = 1'b0;
  logic [7:0] byteNext = '0;
  int base;

  // {select, write data, expected readback}
  localparam logic [18:0] VECS [9] = '{
    {3'd0, 8'hFF, 8'hFE}, {3'd1, 8'hFF, 8'h3F}, {3'd5, 8'hAA, 8'h00},
    {3'd6, 8'hAA, 8'h00}, {3'd7, 8'hAA, 8'h00}, {3'd1, 8'h15, 8'h15},
    {3'd0, 8'h55, 8'h54}, {3'd2, 8'h40, 8'h40}, {3'd2, 8'h03, 8'h00}
  };

  always #2 clk = ~clk;

  i2c_host_regs dut (
    .clk(clk), .rstN(rstN), .regSel(regSel), .regWrEn(regWrEn),
    .regRdEn(regRdEn), .regWdata(regWdata), .regRdata(regRdata),
    .regReady(regReady), .cmdValid(cmdValid), .cmdReady(cmdReady),
    .cmdOp(cmdOp), .cmdByte(cmdByte), .respValid(respValid),
    .respNack(respNack), .respLost(respLost), .respByte(respByte), .irq(irq)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got 0x%02h expected 0x%02h", req, act, exp);
    end
  endtask

  task automatic access(input logic [2:0] sel, input logic wr,
                        input logic [7:0] wd, output logic [7:0] rdOut);
    @(negedge clk);
    regSel = sel; regWdata = wd; regWrEn = wr; regRdEn = !wr;
    stallCnt = 0;
    forever begin
      #1;
      if (regReady) break;
      stallCnt++;
      @(negedge clk);
    end
    rdOut = regRdata;
    @(posedge clk);
    #1 regWrEn = 1'b0; regRdEn = 1'b0;
  endtask

  task automatic wr(input logic [2:0] sel, input logic [7:0] wd);
    logic [7:0] dummy;
    access(sel, 1'b1, wd, dummy);
  endtask

  task automatic rdReg(input logic [2:0] sel, output logic [7:0] v);
    access(sel, 1'b0, 8'h00, v);
  endtask

  // bit-level engine model
  initial begin
    forever begin
      @(negedge clk); #1;
      if (cmdValid) begin
        @(negedge clk);
        cmdReady = 1'b1;
        prevOp = lastOp; lastOp = cmdOp; lastByte = cmdByte; cmdCount++;
        @(posedge clk); #1 cmdReady = 1'b0;
        repeat (2) @(negedge clk);
        respValid = 1'b1; respNack = nackNext; respLost = lostNext; respByte = byteNext;
        @(posedge clk); #1 respValid = 1'b0; respNack = 1'b0; respLost = 1'b0;
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got 0x00 expected 0x01 (run did not finish)");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;

    // reset state
    for (int s = 0; s < 5; s++) begin
      rdReg(3'(s), rd); check("R1 reset value", rd, 8'h00);
    end
    check("R5 reset irq", {7'd0, irq}, 8'h00);

    // R1 mask and unmapped table
    for (int i = 0; i < 9; i++) begin
      wr(VECS[i][18:16], VECS[i][15:8]);
      rdReg(VECS[i][18:16], rd);
      check("R1 masked readback", rd, VECS[i][7:0]);
    end

    // R7 master set but disabled: data write ignored
    wr(3'd2, 8'h20);
    base = cmdCount;
    wr(3'd4, 8'h33);
    check("R7 no command when disabled", 8'(cmdCount - base), 8'h00);
    check("R11 plain access no stall", 8'(stallCnt), 8'h00);
    wr(3'd2, 8'h00);

    // R3 busy follows master bit
    wr(3'd2, 8'hC0); rdReg(3'd3, rd); check("R3 busy clear", rd, 8'h00);
    wr(3'd2, 8'hE0); rdReg(3'd3, rd); check("R3 busy set", rd, 8'h20);

    // R8 address phase with ACK
    base = cmdCount;
    wr(3'd4, 8'hA0);
    check("R8 start opcode", {6'd0, lastOp}, 8'h00);
    check("R8 start byte", lastByte, 8'hA0);
    check("R11 bus access stalls", 8'(stallCnt > 0), 8'h01);
    rdReg(3'd3, rd); check("R8 status after ack", rd, 8'h22);
    check("R6 irq line", {7'd0, irq}, 8'h01);

    // R5 write-zero-to-clear
    wr(3'd3, 8'hFF); rdReg(3'd3, rd); check("R5 ones set nothing", rd, 8'h22);
    wr(3'd3, 8'h00); rdReg(3'd3, rd); check("R5 flag cleared", rd, 8'h20);
    check("R5 irq low", {7'd0, irq}, 8'h00);

    // R9 send with ACK
    wr(3'd4, 8'h5A);
    check("R9 send opcode", {6'd0, lastOp}, 8'h01);
    check("R9 send byte", lastByte, 8'h5A);
    rdReg(3'd3, rd); check("R9 status after ack", rd, 8'h22);
    wr(3'd3, 8'h00);

    // R9 send with NACK -> stop, address dropped
    nackNext = 1'b1; base = cmdCount;
    wr(3'd4, 8'h77);
    nackNext = 1'b0;
    check("R9 nack two commands", 8'(cmdCount - base), 8'h02);
    check("R9 nack then stop", {prevOp, lastOp}, {6'd0, 2'd1, 2'd3});
    rdReg(3'd3, rd); check("R9 nack status", rd, 8'h21);
    wr(3'd4, 8'hA1);
    check("R9 next write is address", {6'd0, lastOp}, 8'h00);
    rdReg(3'd3, rd); check("R8 nack flag cleared", rd, 8'h22);
    wr(3'd3, 8'h00);

    // R10 pipelined read
    byteNext = 8'h3C; rdReg(3'd4, rd);
    check("R10 first read returns old latch", rd, 8'h00);
    check("R10 receive opcode", {6'd0, lastOp}, 8'h02);
    rdReg(3'd3, rd); check("R10 irq after receive", rd, 8'h22);
    wr(3'd3, 8'h00);
    byteNext = 8'h4D; rdReg(3'd4, rd);
    check("R10 second read returns first byte", rd, 8'h3C);
    wr(3'd3, 8'h00);

    // R4 repeated start with active transfer
    base = cmdCount;
    wr(3'd2, 8'hE4);
    check("R4 stop issued", {6'd0, lastOp}, 8'h03);
    rdReg(3'd2, rd); check("R4 bit reads zero", rd, 8'hE0);

    // R10 master read with no address
    base = cmdCount;
    rdReg(3'd4, rd); check("R10 read without address", rd, 8'h4D);
    check("R10 no command", 8'(cmdCount - base), 8'h00);
    rdReg(3'd4, rd); check("R10 latch became 0xFF", rd, 8'hFF);

    // R6 interrupt gated by enable bit
    wr(3'd2, 8'hA0);
    wr(3'd4, 8'hB0);
    rdReg(3'd3, rd); check("R6 no flag without enable", rd, 8'h20);
    check("R6 irq stays low", {7'd0, irq}, 8'h00);

    // R11 arbitration lost
    lostNext = 1'b1; wr(3'd4, 8'h11); lostNext = 1'b0;
    rdReg(3'd3, rd); check("R11 arbitration flag", rd, 8'h30);
    wr(3'd3, 8'h00); rdReg(3'd3, rd); check("R5 arbitration cleared", rd, 8'h20);

    // R3 leave master mode with active transfer
    base = cmdCount;
    wr(3'd2, 8'h80);
    check("R3 stop on master clear", {6'd0, lastOp}, 8'h03);
    check("R3 one command", 8'(cmdCount - base), 8'h01);
    rdReg(3'd3, rd); check("R3 busy dropped", rd, 8'h00);

    // R2 soft reset with active transfer and pending interrupt
    wr(3'd1, 8'h2A);
    wr(3'd2, 8'hE0);
    wr(3'd4, 8'hA0);
    check("R2 irq before soft reset", {7'd0, irq}, 8'h01);
    base = cmdCount;
    wr(3'd2, 8'h00);
    check("R2 stop on soft reset", {6'd0, lastOp}, 8'h03);
    rdReg(3'd0, rd); check("R2 own address kept", rd, 8'h54);
    rdReg(3'd1, rd); check("R2 divider cleared", rd, 8'h00);
    rdReg(3'd2, rd); check("R2 control cleared", rd, 8'h00);
    rdReg(3'd3, rd); check("R2 status cleared", rd, 8'h00);
    rdReg(3'd4, rd); check("R2 data latch cleared", rd, 8'h00);
    check("R2 irq low", {7'd0, irq}, 8'h00);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule